// File: doc/BRIEF.md
# Converter Output Formatter with Overrange Flag

This block sits behind the decimation filter of a data converter. Each sample period the filter hands it one wide signed result together with a single-cycle valid pulse. The block limits that result to a 16-bit two's complement word. It raises an overrange flag when the result lies beyond either end of the 16-bit range. It announces each new word with an active-low data-ready strobe that lasts one clock. A host reads the word over a parallel bus that is enabled only while chip-select and read are both low.

An active-low sync input clears the block asynchronously, whatever the clock is doing. While sync is low the word and the flag are zero and data-ready is held high. After sync is released, the strobe restarts with a fixed latency. Several converters that share one clock can therefore be released together, and their strobes then line up. The bus's high-impedance state is modelled as an output-enable next to a 16-bit data port, and that port reads zero whenever the enable is low.

Top module: `fmt_out_formatter`

## Requirements
- R1: A result inside the range -32768..32767 appears unchanged as its low 16 bits on the word, with the overrange flag low.
- R2: A result greater than 32767 gives the word 7FFFh and sets the overrange flag.
- R3: A result less than -32768 gives the word 8000h and sets the overrange flag.
- R4: The limits themselves, 32767 and -32768, are in range (flag low). The nearest values outside them, 32768 and -32769, are clipped and flagged.
- R5: The word and the flag change only at the clock edge where data-ready falls. They hold between strobes even if the filter result changes. The flag stays high across successive out-of-range samples and returns low with the first in-range sample.
- R6: A valid pulse sampled at a rising edge makes data-ready low from that edge until the next rising edge, with the new word and flag already present.
- R7: The output-enable is high exactly when chip-select and read are both low. While the enable is low the data port reads 0000h.
- R8: While sync is low, data-ready is high, the flag is low and the word is 0000h, taking effect without waiting for a clock edge.
- R9: After sync is released between clock edges, data-ready stays high through the first rising edge and falls at the second. A valid pulse at that first edge is ignored.
- R10: If no valid pulse accompanies the second edge after release, that first strobe presents the word 0000h with the flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Running sample clock |
| sync_n | input | 1 | Active-low asynchronous clear and strobe restart |
| res_valid | input | 1 | Single-cycle pulse marking a new filter result |
| res_data | input | IN_W | Signed filter result, two's complement |
| cs_n | input | 1 | Active-low chip-select for the read bus |
| rd_n | input | 1 | Active-low read for the read bus |
| dout | output | 16 | Output word; 0000h while not enabled |
| dout_oe | output | 1 | High while the bus is driven |
| drdy_n | output | 1 | Active-low data-ready strobe |
| ovr | output | 1 | Overrange flag for the word currently held |

## Verification
The checks assume that the filter never raises its valid pulse on two consecutive edges. They also assume that sync changes only between clock edges, never on a rising edge. Under those conditions, a one-clock data-ready pulse and a fixed two-edge restart are well-defined properties. The stimulus drives every input on the falling clock edge and sends each sample as an isolated single-cycle pulse followed by at least one idle cycle. Sync is released on a falling edge and asserted a moment after one. The bench applies results beyond both limits only through the declared input width, so the clip direction always follows the true sign.

// File: rtl/fmt_pkg.sv
// Package: shared width and the restart phase type for the output formatter.
// Assumes: the output word is always 16 bits wide.
package fmt_pkg;
    localparam int OUT_W = 16;

    typedef logic [OUT_W-1:0] word_t;

    // Restart sequencing after sync release
    typedef enum logic [1:0] {
        PH_CLEAR = 2'd0,   // first edge after release: arm only
        PH_ARM   = 2'd1,   // second edge: forced first strobe
        PH_RUN   = 2'd2    // normal operation
    } phase_t;
endpackage

// File: rtl/fmt_saturate.sv
// Module: fmt_saturate
// Limits a wide signed result to the 16-bit two's complement range and
// reports whether limiting took place. Purely combinational.
// Assumes: IN_W >= 18 so both overflow directions are representable.
module fmt_saturate
    import fmt_pkg::*;
#(
    parameter int IN_W = 20
) (
    input  logic [IN_W-1:0] res_i,
    output word_t           word_o,
    output logic            over_o
);
    // Bits that must all match the output sign bit for the value to fit
    localparam int HEAD_W = IN_W - OUT_W + 1;

    logic [HEAD_W-1:0] head;
    logic              fits;

    // Decide range and pick the passed or clipped word
    always_comb begin
        head   = res_i[IN_W-1:OUT_W-1];
        fits   = (&head) | ~(|head);
        over_o = ~fits;
        if (fits) begin
            word_o = res_i[OUT_W-1:0];
        end else if (res_i[IN_W-1]) begin
            word_o = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            word_o = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/fmt_sequencer.sv
// Module: fmt_sequencer
// Owns the data-ready strobe and the restart timing after sync release.
// One edge arms, the next forces a first strobe; after that each accepted
// valid pulse gives a one-clock low strobe.
// Assumes: valid pulses are separated by at least one idle edge; a pulse
// arriving while the strobe is low is dropped.
module fmt_sequencer
    import fmt_pkg::*;
(
    input  logic clk,
    input  logic sync_n,
    input  logic res_valid,
    output logic load_o,
    output logic drdy_n
);
    phase_t phase_q;
    logic   strobe;

    // Accept a sample once armed and not directly after a strobe
    always_comb begin
        load_o = res_valid && (phase_q != PH_CLEAR) && drdy_n;
        strobe = (phase_q == PH_ARM) || load_o;
    end

    // Advance the restart phase
    always_ff @(posedge clk or negedge sync_n) begin
        if (!sync_n) begin
            phase_q <= PH_CLEAR;
        end else begin
            case (phase_q)
                PH_CLEAR: phase_q <= PH_ARM;
                PH_ARM:   phase_q <= PH_RUN;
                default:  phase_q <= PH_RUN;
            endcase
        end
    end

    // Register the active-low strobe
    always_ff @(posedge clk or negedge sync_n) begin
        if (!sync_n) begin
            drdy_n <= 1'b1;
        end else begin
            drdy_n <= ~strobe;
        end
    end
endmodule

// File: rtl/fmt_outreg.sv
// Module: fmt_outreg
// Holds the presented word and overrange flag. Both load together on the
// edge that lowers the strobe and hold otherwise.
// Assumes: load_i is high only at strobe edges.
module fmt_outreg
    import fmt_pkg::*;
(
    input  logic  clk,
    input  logic  sync_n,
    input  logic  load_i,
    input  word_t word_i,
    input  logic  over_i,
    output word_t word_q,
    output logic  ovr_q
);
    // Capture word and flag as one pair
    always_ff @(posedge clk or negedge sync_n) begin
        if (!sync_n) begin
            word_q <= '0;
            ovr_q  <= 1'b0;
        end else if (load_i) begin
            word_q <= word_i;
            ovr_q  <= over_i;
        end
    end
endmodule

// File: rtl/fmt_busgate.sv
// Module: fmt_busgate
// Models the tri-state read bus as an enable plus a data port that reads
// zero when not enabled. Combinational.
// Assumes: cs_n and rd_n are already synchronous to the reader.
module fmt_busgate
    import fmt_pkg::*;
(
    input  logic  cs_n,
    input  logic  rd_n,
    input  word_t word_i,
    output word_t dout,
    output logic  dout_oe
);
    // Enable only on both selects low
    always_comb begin
        dout_oe = ~cs_n & ~rd_n;
        dout    = dout_oe ? word_i : '0;
    end
endmodule

// File: rtl/fmt_out_formatter.sv
// Module: fmt_out_formatter (top)
// Converter back end: saturates the filter result to 16 bits, flags
// overrange, strobes data-ready and drives the gated read bus.
// Assumes: IN_W >= 18; sync_n changes away from rising clock edges.
module fmt_out_formatter
    import fmt_pkg::*;
#(
    parameter int IN_W = 20
) (
    input  logic            clk,
    input  logic            sync_n,
    input  logic            res_valid,
    input  logic [IN_W-1:0] res_data,
    input  logic            cs_n,
    input  logic            rd_n,
    output logic [15:0]     dout,
    output logic            dout_oe,
    output logic            drdy_n,
    output logic            ovr
);
    word_t sat_word;
    logic  sat_over;
    logic  load;
    word_t word_q;

    fmt_saturate #(.IN_W(IN_W)) u_sat (
        .res_i  (res_data),
        .word_o (sat_word),
        .over_o (sat_over)
    );

    fmt_sequencer u_seq (
        .clk       (clk),
        .sync_n    (sync_n),
        .res_valid (res_valid),
        .load_o    (load),
        .drdy_n    (drdy_n)
    );

    fmt_outreg u_reg (
        .clk    (clk),
        .sync_n (sync_n),
        .load_i (load),
        .word_i (sat_word),
        .over_i (sat_over),
        .word_q (word_q),
        .ovr_q  (ovr)
    );

    fmt_busgate u_bus (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .word_i  (word_q),
        .dout    (dout),
        .dout_oe (dout_oe)
    );
endmodule

// File: rtl/fmt_out_formatter_chk.sv
// Module: fmt_out_formatter_chk
// Property checker for the output formatter, bound to the top module.
// Assumes: valid pulses are isolated and sync moves between edges.
module fmt_out_formatter_chk (
    input logic        clk,
    input logic        sync_n,
    input logic        res_valid,
    input logic        cs_n,
    input logic        rd_n,
    input logic [15:0] dout,
    input logic        dout_oe,
    input logic        drdy_n,
    input logic        ovr,
    input logic [15:0] word_q
);
    // Input assumption behind R6: no back-to-back valid pulses
    p_valid_gap_r6: assert property (@(posedge clk) disable iff (!sync_n)
        res_valid |=> !res_valid);

    // R6: strobe is low for a single clock
    p_drdy_pulse_r6: assert property (@(posedge clk) disable iff (!sync_n)
        !drdy_n |=> drdy_n);

    // R5: flag moves only where data-ready falls
    p_ovr_on_strobe_r5: assert property (@(posedge clk) disable iff (!sync_n)
        !$stable(ovr) |-> $fell(drdy_n));

    // R5: word moves only where data-ready falls
    p_word_on_strobe_r5: assert property (@(posedge clk) disable iff (!sync_n)
        !$stable(word_q) |-> $fell(drdy_n));

    // R2 R3: a flagged word is one of the two clip values
    p_clip_value_r2: assert property (@(posedge clk) disable iff (!sync_n)
        ovr |-> (word_q == 16'h7FFF || word_q == 16'h8000));

    // R7: selected bus shows the held word
    p_bus_on_r7: assert property (@(posedge clk) disable iff (!sync_n)
        (!cs_n && !rd_n) |-> (dout_oe && dout == word_q));

    // R7: deselected bus is off and reads zero
    p_bus_off_r7: assert property (@(posedge clk) disable iff (!sync_n)
        (cs_n || rd_n) |-> (!dout_oe && dout == 16'h0000));

    // R8: cleared state while sync is low
    p_sync_clear_r8: assert property (@(posedge clk)
        !sync_n |-> (drdy_n && !ovr && word_q == 16'h0000));

    // R9: strobe high at the first edge after release, low after the second
    p_restart_r9: assert property (@(posedge clk) disable iff (!sync_n)
        $rose(sync_n) |=> drdy_n ##1 !drdy_n);
endmodule

bind fmt_out_formatter fmt_out_formatter_chk u_chk (
    .clk       (clk),
    .sync_n    (sync_n),
    .res_valid (res_valid),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .drdy_n    (drdy_n),
    .ovr       (ovr),
    .word_q    (word_q)
);

// File: tb/tb_fmt_out_formatter.sv
// Testbench for fmt_out_formatter: vector table walk, then directed tests.
module tb_fmt_out_formatter;
    localparam int IN_W = 20;
    localparam int NV   = 10;

    logic            clk;
    logic            sync_n;
    logic            res_valid;
    logic [IN_W-1:0] res_data;
    logic            cs_n;
    logic            rd_n;
    logic [15:0]     dout;
    logic            dout_oe;
    logic            drdy_n;
    logic            ovr;

    int checks   = 0;
    int failures = 0;

    // {input result, expected word, expected flag}
    localparam logic [36:0] VEC [NV] = '{
        {20'h00064, 16'h0064, 1'b0},   // R1 +100
        {20'hFFF9C, 16'hFF9C, 1'b0},   // R1 -100
        {20'h00000, 16'h0000, 1'b0},   // R1 zero
        {20'h07FFF, 16'h7FFF, 1'b0},   // R4 top limit
        {20'hF8000, 16'h8000, 1'b0},   // R4 bottom limit
        {20'h08000, 16'h7FFF, 1'b1},   // R4 one above
        {20'hF7FFF, 16'h8000, 1'b1},   // R4 one below
        {20'h7FFFF, 16'h7FFF, 1'b1},   // R2 largest input
        {20'h80000, 16'h8000, 1'b1},   // R3 smallest input
        {20'h01234, 16'h1234, 1'b0}    // R1 back in range
    };

    fmt_out_formatter #(.IN_W(IN_W)) dut (
        .clk       (clk),
        .sync_n    (sync_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .drdy_n    (drdy_n),
        .ovr       (ovr)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One isolated sample; checks the strobe cycle and the cycle after
    task automatic send(input string req, input logic [IN_W-1:0] v,
                        input logic [15:0] ew, input logic eo);
        res_valid = 1'b1;
        res_data  = v;
        tick();
        res_valid = 1'b0;
        chk({req, " R6 strobe low"}, {31'd0, drdy_n}, 32'd0);
        chk({req, " word"}, {16'd0, dout}, {16'd0, ew});
        chk({req, " flag"}, {31'd0, ovr}, {31'd0, eo});
        tick();
        chk({req, " R6 strobe back high"}, {31'd0, drdy_n}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        sync_n = 1'b1; res_valid = 1'b0; res_data = '0; cs_n = 1'b0; rd_n = 1'b0;
        #1 sync_n = 1'b0;
        repeat (3) tick();
        chk("R8 drdy high in reset", {31'd0, drdy_n}, 32'd1);
        chk("R8 flag low in reset", {31'd0, ovr}, 32'd0);
        chk("R8 word zero in reset", {16'd0, dout}, 32'd0);

        // R9: release with a valid pulse at the first edge, which is ignored
        sync_n = 1'b1; res_valid = 1'b1; res_data = 20'h01234;
        tick();
        res_valid = 1'b0;
        chk("R9 drdy high after first edge", {31'd0, drdy_n}, 32'd1);
        tick();
        chk("R9 drdy low after second edge", {31'd0, drdy_n}, 32'd0);
        chk("R10 startup word zero", {16'd0, dout}, 32'd0);
        chk("R10 startup flag low", {31'd0, ovr}, 32'd0);
        tick();
        chk("R6 startup strobe one clock", {31'd0, drdy_n}, 32'd1);

        // Table walk: R1 R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            send("R1-table", VEC[i][36:17], VEC[i][16:1], VEC[i][0]);
            tick();
        end

        // R5: flag persistence and hold between strobes
        send("R2 far over", 20'h30000, 16'h7FFF, 1'b1);
        res_data = 20'h00005;
        repeat (3) tick();
        chk("R5 word held between strobes", {16'd0, dout}, 32'h7FFF);
        chk("R5 flag held between strobes", {31'd0, ovr}, 32'd1);
        send("R5 stays flagged", 20'hF0000, 16'h8000, 1'b1);
        tick();
        send("R5 flag clears", 20'h00005, 16'h0005, 1'b0);
        tick();

        // R7: bus enable truth table
        cs_n = 1'b1; rd_n = 1'b0; #1;
        chk("R7 cs high oe", {31'd0, dout_oe}, 32'd0);
        chk("R7 cs high data", {16'd0, dout}, 32'd0);
        tick();
        cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R7 rd high oe", {31'd0, dout_oe}, 32'd0);
        chk("R7 rd high data", {16'd0, dout}, 32'd0);
        tick();
        cs_n = 1'b1; rd_n = 1'b1; #1;
        chk("R7 both high oe", {31'd0, dout_oe}, 32'd0);
        tick();
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R7 both low oe", {31'd0, dout_oe}, 32'd1);
        chk("R7 both low data", {16'd0, dout}, 32'h0005);
        tick();

        // R8: asynchronous clear mid-run
        send("R2 before clear", 20'h08000, 16'h7FFF, 1'b1);
        #1 sync_n = 1'b0;
        #1;
        chk("R8 async drdy high", {31'd0, drdy_n}, 32'd1);
        chk("R8 async flag low", {31'd0, ovr}, 32'd0);
        chk("R8 async word zero", {16'd0, dout}, 32'd0);
        tick();
        tick();
        sync_n = 1'b1;
        tick();
        chk("R9 restart drdy high", {31'd0, drdy_n}, 32'd1);
        tick();
        chk("R9 restart drdy low", {31'd0, drdy_n}, 32'd0);
        chk("R10 restart word zero", {16'd0, dout}, 32'd0);
        tick();
        tick();
        send("R1 after restart", 20'h00007, 16'h0007, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule